// File: doc/BRIEF.md
# Edge-Pulse Isolated Level Link

This block models a one-bit link across an isolation barrier. A transmit half watches a single logic input and turns each change of that input into a one-cycle pulse on one of two lines. A rise goes out on the set line and a fall goes out on the clear line. A receive half holds its output in a set/clear storage element that follows those pulses.

While the input stays quiet, the transmit half repeats its current level as a refresh pulse at a fixed interval. The receiver therefore recovers the correct DC level even if a pulse is lost. The receive half also keeps a watchdog. If no pulse of either kind arrives for a long interval, the transmitter is assumed dead and the output is driven high.

The link carries a level and not a stream of words, so it has no valid/ready handshake and applies no back-pressure. The input is sampled every clock. Both intervals are parameters in clock cycles, and `WDOG_CYC` must exceed `REFRESH_CYC`. A `tx_en` pin models power to the transmit half.

Top module: `isolink_top`

## Requirements
- R1: A rising `din` sends exactly one pulse on `link_set` and a falling `din` exactly one on `link_clr`. The pulse is visible in the third cycle after the cycle in which `din` changed, because of a two-flop synchronizer and a pulse register.
- R2: The receiver drives `dout` high in the cycle after a set pulse and low in the cycle after a clear pulse, and holds it otherwise. In steady operation `dout` equals `din` delayed by four cycles.
- R3: When `din` has had no transition for `REFRESH_CYC` cycles, a refresh pulse is sent on the line matching the synchronized level (set for 1, clear for 0). It repeats every `REFRESH_CYC` cycles while the input stays idle.
- R4: Every transition restarts the idle count, so the first refresh comes `REFRESH_CYC` cycles after the edge pulse. When an edge and a refresh fall in the same cycle, only the edge pulse is sent, and the next refresh is `REFRESH_CYC` cycles after it.
- R5: If no pulse arrives for `WDOG_CYC` cycles, `dout` goes high in the following cycle. Every received pulse restarts this count, so a live transmitter never trips it.
- R6: Every pulse lasts exactly one cycle, and the two lines are never high in the same cycle.
- R7: After the watchdog has forced `dout` high, the next set or clear pulse resumes normal decoding.
- R8: While `rst_n` is low at a clock edge (synchronous, active low), `dout` becomes 1, both link lines become 0, and both counters clear.
- R9: While `tx_en` is 0 the transmit half sends no pulses and its state is cleared. When `tx_en` is raised with `din` high, a set pulse appears in the third cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit half powered when 1 |
| din | input | 1 | Logic level to carry across |
| dout | output | 1 | Recovered level |
| link_set | output | 1 | Set pulse line between the halves |
| link_clr | output | 1 | Clear pulse line between the halves |

## Verification
On every cycle, assertions check the following:
- the pulse lines are one-cycle and mutually exclusive;
- the transmit half stays silent when disabled;
- the receiver responds to each pulse kind;
- the receiver holds its level between pulses;
- the output goes high once the watchdog count expires.

Only the bench scenarios can show:
- the exact refresh spacing and its restart at an edge;
- priority when an edge lands on a refresh slot;
- the four-cycle end-to-end latency under random toggling;
- the watchdog firing time when the transmitter is switched off;
- recovery after the watchdog has fired.

// File: rtl/isolink_pkg.sv
package isolink_pkg;
  typedef struct packed {
    logic set;
    logic clr;
  } link_t;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/isolink_sync.sv
module isolink_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) chain <= '0;
    else                 chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/isolink_enc.sv
module isolink_enc
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 125
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  din,
  output link_t link_o
);
  localparam int unsigned CW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [CW-1:0] IDLE_LAST = CW'(REFRESH_CYC - 1);

  logic          lvl;
  logic          prev_lvl;
  logic [CW-1:0] idle_cnt;
  logic          edge_seen;
  logic          refresh_due;
  logic          fire;

  isolink_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!en),
    .d     (din),
    .q     (lvl)
  );

  assign edge_seen   = lvl ^ prev_lvl;
  assign refresh_due = (idle_cnt == IDLE_LAST);
  // an edge and a due refresh share one pulse; the count restarts either way
  assign fire        = edge_seen | refresh_due;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      prev_lvl <= 1'b0;
      idle_cnt <= '0;
      link_o   <= '0;
    end else begin
      prev_lvl   <= lvl;
      idle_cnt   <= fire ? '0 : idle_cnt + 1'b1;
      link_o.set <= fire & lvl;
      link_o.clr <= fire & ~lvl;
    end
  end

  p_lines_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_o.set, link_o.clr}));
  p_set_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_o.set |=> !link_o.set);
  p_clr_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_o.clr |=> !link_o.clr);
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!link_o.set && !link_o.clr));
endmodule

// File: rtl/isolink_dec.sv
module isolink_dec
  import isolink_pkg::*;
#(
  parameter int unsigned WDOG_CYC = 625
) (
  input  logic  clk,
  input  logic  rst_n,
  input  link_t link_i,
  output logic  dout
);
  localparam int unsigned WW = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(WDOG_CYC - 1);

  logic [WW-1:0] wd_cnt;
  logic          any_pulse;

  assign any_pulse = link_i.set | link_i.clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout   <= 1'b1;
      wd_cnt <= '0;
    end else if (any_pulse) begin
      dout   <= link_i.set;
      wd_cnt <= '0;
    end else if (wd_cnt == WD_LAST) begin
      dout   <= 1'b1;
    end else begin
      wd_cnt <= wd_cnt + 1'b1;
    end
  end

  p_set_drives_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_i.set |=> dout);
  p_clr_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i.clr && !link_i.set) |=> !dout);
  p_holds_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_pulse && wd_cnt != WD_LAST) |=> $stable(dout));
  p_wdog_forces_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_pulse && wd_cnt == WD_LAST) |=> dout);
endmodule

// File: rtl/isolink_top.sv
module isolink_top
  import isolink_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 125,
  parameter int unsigned WDOG_CYC    = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic din,
  output logic dout,
  output logic link_set,
  output logic link_clr
);
  link_t link;

  isolink_enc #(.REFRESH_CYC(REFRESH_CYC)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tx_en),
    .din    (din),
    .link_o (link)
  );

  isolink_dec #(.WDOG_CYC(WDOG_CYC)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .link_i (link),
    .dout   (dout)
  );

  assign link_set = link.set;
  assign link_clr = link.clr;
endmodule

// File: tb/test_isolink_top.sv
`timescale 1ns/1ps
module test_isolink_top;
  localparam int R = 16;
  localparam int W = 40;

  logic clk = 1'b0;
  logic rst_n, tx_en, din;
  logic dout, link_set, link_clr;
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  isolink_top #(.REFRESH_CYC(R), .WDOG_CYC(W)) i_isolink_top (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .din(din),
    .dout(dout), .link_set(link_set), .link_clr(link_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for a pulse on the chosen line; counts pulses seen on the other one
  task automatic wait_pulse(input bit want_set, output int at, output int others);
    others = 0;
    at = -1;
    for (int i = 0; i < 4 * W; i++) begin
      @(negedge clk);
      if ((want_set ? link_set : link_clr)) begin
        at = cyc;
        return;
      end
      if ((want_set ? link_clr : link_set)) others++;
    end
  endtask

  function automatic logic exp_dout(input logic [3:0] h);
    return h[3];
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, t1, oth, c0;
    logic [3:0] hist;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tx_en = 1'b1; din = 1'b0;
    step(3);
    check(dout == 1'b1, "R8 dout after reset", dout, 1);
    check(!link_set && !link_clr, "R8 lines after reset", {link_set, link_clr}, 0);
    rst_n = 1'b1;

    // idle low: clear refreshes spaced R apart
    wait_pulse(1'b0, t0, oth);
    wait_pulse(1'b0, t1, oth);
    check(t1 - t0 == R, "R3 low refresh spacing", t1 - t0, R);
    check(oth == 0, "R3 no set while low", oth, 0);
    step(1);
    check(dout == 1'b0, "R2 dout low after clear", dout, 0);
    step(3 * R);
    check(dout == 1'b0, "R5 refresh keeps watchdog quiet", dout, 0);

    // rising edge
    din = 1'b1; c0 = cyc;
    wait_pulse(1'b1, t0, oth);
    check(t0 == c0 + 3, "R1 set pulse timing", t0 - c0, 3);
    check(oth == 0, "R1 no clear on rise", oth, 0);
    step(1);
    check(!link_set, "R6 set lasts one cycle", link_set, 0);
    check(dout == 1'b1, "R2 dout high four cycles after din", dout, 1);

    // refresh high, first measured from the edge
    wait_pulse(1'b1, t1, oth);
    check(t1 - t0 == R, "R4 first refresh after edge", t1 - t0, R);
    wait_pulse(1'b1, t0, oth);
    check(t0 - t1 == R, "R3 high refresh repeats", t0 - t1, R);

    // falling edge landing on the refresh slot
    step(R - 3);
    din = 1'b0;
    step(3);
    check(link_clr && !link_set, "R4 edge wins over refresh",
          {link_set, link_clr}, 1);
    t0 = cyc;
    step(1);
    check(!link_set && !link_clr, "R6 single pulse at collision",
          {link_set, link_clr}, 0);
    wait_pulse(1'b0, t1, oth);
    check(t1 - t0 == R && oth == 0, "R4 refresh after collision", t1 - t0, R);

    // transmitter off: watchdog
    tx_en = 1'b0;
    step(W);
    check(dout == 1'b0, "R5 not yet timed out", dout, 0);
    step(1);
    check(dout == 1'b1, "R5 watchdog forces high", dout, 1);
    wait_pulse(1'b0, t0, oth);
    check(t0 == -1 && oth == 0, "R9 disabled sends nothing", oth, 0);

    // recovery
    tx_en = 1'b1;
    wait_pulse(1'b0, t0, oth);
    step(1);
    check(dout == 1'b0, "R7 decoding resumes after timeout", dout, 0);

    // re-enable with input high
    tx_en = 1'b0; din = 1'b1;
    step(2);
    tx_en = 1'b1; c0 = cyc;
    wait_pulse(1'b1, t0, oth);
    check(t0 == c0 + 3, "R9 set on re-enable with din high", t0 - c0, 3);
    step(4);

    // random toggling, dout tracks din four cycles late
    hist = {4{din}};
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check(dout == exp_dout(hist), "R2 random tracking", dout, exp_dout(hist));
      if (link_set && link_clr)
        check(1'b0, "R6 both lines high", 1, 0);
      if (($urandom % 8) == 0 || (i % 97) == 0) din = $urandom % 2;
      if ((i % 211) == 5) din = ~din;
      hist = {hist[2:0], din};
    end

    // reset mid-run
    rst_n = 1'b0; din = 1'b0;
    step(1);
    check(dout == 1'b1, "R8 dout on reset", dout, 1);
    rst_n = 1'b1;
    step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule